// File: doc/BRIEF.md
# Oscillator Start-Up Race Supervisor

This block picks the system clock source after a cold start or a wake from low-power stop. It runs a stabilization counter on the main crystal clock and a watchdog counter on the internal oscillator, and it starts both at once. If the main-clock counter finishes first, the crystal is trusted and the system runs from it. If the watchdog finishes first, the block falls back to the internal oscillator. The CPU stays halted until one of the two counters has won.

The fallback decision is sticky, and only a reset can undo it. While the CPU runs from the crystal, a clock-monitor input can also force the fallback. Each time the fallback is entered with the CPU running, the watchdog length register is write-protected for a fixed number of internal-oscillator cycles. A misconfiguration flag warns when the chosen watchdog length is shorter than the stabilization length, because the crystal would then always lose the race. Software programs both lengths through a small write port.

Top module: `osc_race_sup`

## Requirements
- R1: After reset is released the race starts at once. `cpu_run` and `sel_main` are 0 during reset and while the race runs.
- R2: If the main-clock count finishes first, `sel_main`=1, `fallback`=0 and `cpu_run`=1 follow. The finish event crosses into the internal domain through two flops, so a 2^13 main-clock count takes about 2^13 main periods plus a few internal cycles.
- R3: If the watchdog reaches its length first, `fallback`=1, `sel_main`=0 and `cpu_run`=1 follow. If both finish in the same internal cycle, the watchdog wins.
- R4: The stabilization length is 2^(13+s) main cycles. s is written with `cfg_addr`=0, is limited to 0..8, and resets to 0 when `opt_long`=0 or to 2 (2^15) when `opt_long`=1.
- R5: The watchdog length is 2^(12+w) internal cycles. w is written with `cfg_addr`=1, is limited to 0..7, and resets to 7.
- R6: Once `fallback` is 1, only `rst` clears it. `stop_req`, `wake_irq`, a restarted main clock and register writes leave it at 1, and while it is set `cpu_run` stays 1.
- R7: In normal mode `stop_req` drops `cpu_run` on the next cycle. A later `wake_irq` starts a new race with the current lengths.
- R8: When the CPU starts in fallback mode, `wr_lock` is 1 for exactly 1024 internal cycles. Writes to w are ignored during that time. Writes to s are still accepted.
- R9: With the CPU running in normal mode, `main_lost`=1 sets `fallback`, clears `sel_main` and starts the R8 lockout. `cpu_run` stays 1.
- R10: `misconfig` is 1, two cycles after a write, when 12+w+1 < 13+s. The +1 is the log2 of the nominal main-to-internal frequency ratio.
- R11: `cpu_run` rises one cycle after `sel_main` has taken its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal-oscillator clock, which clocks the control logic |
| clk_main | input | 1 | Main crystal clock, which may be stopped |
| rst | input | 1 | Synchronous active-high reset (external or watchdog) |
| opt_long | input | 1 | Static option that picks the reset stabilization length |
| stop_req | input | 1 | CPU request to enter stop mode |
| wake_irq | input | 1 | Interrupt that ends stop mode |
| main_lost | input | 1 | Clock monitor reports that the main clock has stopped |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: stabilization select, 1: watchdog select |
| cfg_wdata | input | 4 | Write data |
| sel_main | output | 1 | 1 selects the main clock |
| fallback | output | 1 | Internal-oscillator operation mode |
| cpu_run | output | 1 | CPU start enable |
| wr_lock | output | 1 | Watchdog select write lockout active |
| misconfig | output | 1 | Watchdog length shorter than stabilization length |

## Verification
The assertions assume that `main_lost` is raised only while the CPU is running, that `stop_req` and `wake_irq` are single-cycle pulses, and that `opt_long` does not change while reset is released. The stimulus changes every input on the falling edge of `clk_int` only. It keeps `clk_main` toggling or holds it still, and it never makes its period depend on the race. It starts and stops the main clock only while the CPU is halted or running, never in the middle of a count that is being checked.

// File: rtl/osc_race_pkg.sv
package osc_race_pkg;

    typedef enum logic [1:0] {
        ST_RACE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_STOP   = 2'd3
    } race_state_e;

    localparam logic ADDR_STAB = 1'b0;
    localparam logic ADDR_WDOG = 1'b1;

    function automatic logic [31:0] pow2_mask(input logic [31:0] e);
        return (32'd1 << e) - 32'd1;
    endfunction

endpackage

// File: rtl/osc_race_stab.sv
module osc_race_stab #(
    parameter int unsigned MIN_EXP = 13,
    parameter int unsigned MAX_EXP = 21,
    parameter int unsigned SEL_W   = 4
) (
    input  logic             clk_main_i,
    input  logic             clk_int_i,
    input  logic             rst_i,
    input  logic             go_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    import osc_race_pkg::*;

    localparam int unsigned CNT_W = MAX_EXP;

    logic             go_m1, go_m2;
    logic [CNT_W-1:0] cnt_q;
    logic             done_m;
    logic [31:0]      limit;
    logic             ret1, ret2;

    assign limit = pow2_mask(32'(MIN_EXP) + 32'(sel_i));

    // Main-clock domain: the start level is cleared at once and set through two flops
    always_ff @(posedge clk_main_i or negedge go_i) begin
        if (!go_i) begin
            go_m1  <= 1'b0;
            go_m2  <= 1'b0;
            cnt_q  <= '0;
            done_m <= 1'b0;
        end else begin
            go_m1 <= 1'b1;
            go_m2 <= go_m1;
            if (go_m2 && !done_m) begin
                if (32'(cnt_q) == limit) begin
                    done_m <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Return path into the internal-oscillator domain
    always_ff @(posedge clk_int_i) begin
        if (rst_i) begin
            ret1 <= 1'b0;
            ret2 <= 1'b0;
        end else begin
            ret1 <= done_m;
            ret2 <= ret1;
        end
    end

    assign done_o = ret2;

endmodule

// File: rtl/osc_race_wdog.sv
module osc_race_wdog #(
    parameter int unsigned MIN_EXP = 12,
    parameter int unsigned MAX_EXP = 19,
    parameter int unsigned SEL_W   = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             over_o
);
    import osc_race_pkg::*;

    localparam int unsigned CNT_W = MAX_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      limit;

    assign limit = pow2_mask(32'(MIN_EXP) + 32'(sel_i));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over_o = run_i && (32'(cnt_q) == limit);

endmodule

// File: rtl/osc_race_cfg.sv
module osc_race_cfg #(
    parameter int unsigned STAB_MIN_EXP  = 13,
    parameter int unsigned STAB_MAX_EXP  = 21,
    parameter int unsigned STAB_LONG_EXP = 15,
    parameter int unsigned WD_MIN_EXP    = 12,
    parameter int unsigned WD_MAX_EXP    = 19,
    parameter int unsigned RATIO_LOG2    = 1,
    parameter int unsigned LOCK_CYCLES   = 1024,
    parameter int unsigned CFG_W         = 4,
    parameter int unsigned STAB_SEL_W    = 4,
    parameter int unsigned WD_SEL_W      = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  opt_long_i,
    input  logic                  we_i,
    input  logic                  addr_i,
    input  logic [CFG_W-1:0]      wdata_i,
    input  logic                  lock_start_i,
    output logic [STAB_SEL_W-1:0] stab_sel_o,
    output logic [WD_SEL_W-1:0]   wd_sel_o,
    output logic                  lock_o,
    output logic                  misconfig_o
);
    import osc_race_pkg::*;

    localparam int unsigned STAB_SPAN = STAB_MAX_EXP - STAB_MIN_EXP;
    localparam int unsigned WD_SPAN   = WD_MAX_EXP - WD_MIN_EXP;
    localparam int unsigned LONG_OFS  = STAB_LONG_EXP - STAB_MIN_EXP;
    localparam int unsigned LOCK_W    = $clog2(LOCK_CYCLES + 1);

    logic [STAB_SEL_W-1:0] stab_q;
    logic [WD_SEL_W-1:0]   wd_q;
    logic [LOCK_W-1:0]     lock_q;
    logic                  mis_q;
    logic                  locked;

    assign locked = (lock_q != '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stab_q <= opt_long_i ? STAB_SEL_W'(LONG_OFS) : '0;
            wd_q   <= WD_SEL_W'(WD_SPAN);
        end else if (we_i) begin
            if (addr_i == ADDR_STAB) begin
                if (32'(wdata_i) > STAB_SPAN) stab_q <= STAB_SEL_W'(STAB_SPAN);
                else                          stab_q <= STAB_SEL_W'(wdata_i);
            end else if (!locked) begin
                if (32'(wdata_i) > WD_SPAN) wd_q <= WD_SEL_W'(WD_SPAN);
                else                        wd_q <= WD_SEL_W'(wdata_i);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lock_q <= '0;
        end else if (lock_start_i) begin
            lock_q <= LOCK_W'(LOCK_CYCLES);
        end else if (locked) begin
            lock_q <= lock_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mis_q <= 1'b0;
        end else begin
            mis_q <= (32'(WD_MIN_EXP) + 32'(wd_q) + 32'(RATIO_LOG2))
                   < (32'(STAB_MIN_EXP) + 32'(stab_q));
        end
    end

    assign stab_sel_o  = stab_q;
    assign wd_sel_o    = wd_q;
    assign lock_o      = locked;
    assign misconfig_o = mis_q;

endmodule

// File: rtl/osc_race_ctrl.sv
module osc_race_ctrl (
    input  logic clk_i,
    input  logic rst_i,
    input  logic wd_over_i,
    input  logic stab_done_i,
    input  logic stop_req_i,
    input  logic wake_irq_i,
    input  logic main_lost_i,
    output logic stab_go_o,
    output logic wd_run_o,
    output logic sel_main_o,
    output logic fallback_o,
    output logic cpu_run_o,
    output logic lock_start_o
);
    import osc_race_pkg::*;

    race_state_e st_q, st_n;
    logic        fb_q, sel_q, go_q;

    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_RACE:   if (wd_over_i || stab_done_i) st_n = ST_SETTLE;
            ST_SETTLE: st_n = ST_RUN;
            ST_RUN:    if (stop_req_i && !fb_q) st_n = ST_STOP;
            ST_STOP:   if (wake_irq_i) st_n = ST_RACE;
            default:   st_n = ST_RACE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= ST_RACE;
            fb_q  <= 1'b0;
            sel_q <= 1'b0;
            go_q  <= 1'b0;
        end else begin
            st_q <= st_n;
            go_q <= (st_n == ST_RACE);
            if (st_q == ST_RACE && wd_over_i) begin
                fb_q  <= 1'b1;
                sel_q <= 1'b0;
            end else if (st_q == ST_RACE && stab_done_i) begin
                sel_q <= 1'b1;
            end else if (st_q == ST_RUN && !fb_q && main_lost_i) begin
                fb_q  <= 1'b1;
                sel_q <= 1'b0;
            end else if (st_q == ST_STOP && wake_irq_i) begin
                sel_q <= 1'b0;
            end
        end
    end

    assign stab_go_o    = go_q;
    assign wd_run_o     = (st_q == ST_RACE);
    assign sel_main_o   = sel_q;
    assign fallback_o   = fb_q;
    assign cpu_run_o    = (st_q == ST_RUN);
    assign lock_start_o = (st_q == ST_SETTLE && fb_q)
                        || (st_q == ST_RUN && !fb_q && main_lost_i);

endmodule

// File: rtl/osc_race_sup.sv
module osc_race_sup #(
    parameter int unsigned STAB_MIN_EXP  = 13,
    parameter int unsigned STAB_MAX_EXP  = 21,
    parameter int unsigned STAB_LONG_EXP = 15,
    parameter int unsigned WD_MIN_EXP    = 12,
    parameter int unsigned WD_MAX_EXP    = 19,
    parameter int unsigned RATIO_LOG2    = 1,
    parameter int unsigned LOCK_CYCLES   = 1024,
    parameter int unsigned CFG_W         = 4
) (
    input  logic             clk_int,
    input  logic             clk_main,
    input  logic             rst,
    input  logic             opt_long,
    input  logic             stop_req,
    input  logic             wake_irq,
    input  logic             main_lost,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             sel_main,
    output logic             fallback,
    output logic             cpu_run,
    output logic             wr_lock,
    output logic             misconfig
);
    localparam int unsigned STAB_SEL_W = $clog2(STAB_MAX_EXP - STAB_MIN_EXP + 1);
    localparam int unsigned WD_SEL_W   = $clog2(WD_MAX_EXP - WD_MIN_EXP + 1);

    logic [STAB_SEL_W-1:0] stab_sel;
    logic [WD_SEL_W-1:0]   wd_sel;
    logic                  stab_go, stab_done;
    logic                  wd_run, wd_over;
    logic                  lock_start;

    osc_race_cfg #(
        .STAB_MIN_EXP (STAB_MIN_EXP),
        .STAB_MAX_EXP (STAB_MAX_EXP),
        .STAB_LONG_EXP(STAB_LONG_EXP),
        .WD_MIN_EXP   (WD_MIN_EXP),
        .WD_MAX_EXP   (WD_MAX_EXP),
        .RATIO_LOG2   (RATIO_LOG2),
        .LOCK_CYCLES  (LOCK_CYCLES),
        .CFG_W        (CFG_W),
        .STAB_SEL_W   (STAB_SEL_W),
        .WD_SEL_W     (WD_SEL_W)
    ) u_cfg (
        .clk_i       (clk_int),
        .rst_i       (rst),
        .opt_long_i  (opt_long),
        .we_i        (cfg_we),
        .addr_i      (cfg_addr),
        .wdata_i     (cfg_wdata),
        .lock_start_i(lock_start),
        .stab_sel_o  (stab_sel),
        .wd_sel_o    (wd_sel),
        .lock_o      (wr_lock),
        .misconfig_o (misconfig)
    );

    osc_race_stab #(
        .MIN_EXP(STAB_MIN_EXP),
        .MAX_EXP(STAB_MAX_EXP),
        .SEL_W  (STAB_SEL_W)
    ) u_stab (
        .clk_main_i(clk_main),
        .clk_int_i (clk_int),
        .rst_i     (rst),
        .go_i      (stab_go),
        .sel_i     (stab_sel),
        .done_o    (stab_done)
    );

    osc_race_wdog #(
        .MIN_EXP(WD_MIN_EXP),
        .MAX_EXP(WD_MAX_EXP),
        .SEL_W  (WD_SEL_W)
    ) u_wdog (
        .clk_i (clk_int),
        .rst_i (rst),
        .run_i (wd_run),
        .sel_i (wd_sel),
        .over_o(wd_over)
    );

    osc_race_ctrl u_ctrl (
        .clk_i       (clk_int),
        .rst_i       (rst),
        .wd_over_i   (wd_over),
        .stab_done_i (stab_done),
        .stop_req_i  (stop_req),
        .wake_irq_i  (wake_irq),
        .main_lost_i (main_lost),
        .stab_go_o   (stab_go),
        .wd_run_o    (wd_run),
        .sel_main_o  (sel_main),
        .fallback_o  (fallback),
        .cpu_run_o   (cpu_run),
        .lock_start_o(lock_start)
    );

endmodule

// File: rtl/osc_race_sup_chk.sv
module osc_race_sup_chk #(
    parameter int unsigned WD_SEL_W = 3
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                sel_main_i,
    input logic                fallback_i,
    input logic                cpu_run_i,
    input logic                wr_lock_i,
    input logic                main_lost_i,
    input logic                cfg_we_i,
    input logic                cfg_addr_i,
    input logic                wd_run_i,
    input logic                wd_over_i,
    input logic                stab_done_i,
    input logic [WD_SEL_W-1:0] wd_sel_i
);

    a_r1_halted_in_race: assert property (@(posedge clk_i) disable iff (rst_i)
        wd_run_i |-> !cpu_run_i);

    a_r2_main_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (wd_run_i && stab_done_i && !wd_over_i) |=> (sel_main_i && !fallback_i));

    a_r3_wdog_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        wd_over_i |=> (fallback_i && !sel_main_i));

    a_r6_fallback_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        fallback_i |=> fallback_i);

    a_r6_fallback_off_main: assert property (@(posedge clk_i) disable iff (rst_i)
        fallback_i |-> !sel_main_i);

    a_r8_locked_write_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_we_i && cfg_addr_i && wr_lock_i) |=> $stable(wd_sel_i));

    a_r9_monitor_forces: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_run_i && !fallback_i && main_lost_i) |=> (fallback_i && cpu_run_i && wr_lock_i));

    a_r11_select_settled: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cpu_run_i) |-> $stable(sel_main_i));

endmodule

bind osc_race_sup osc_race_sup_chk #(.WD_SEL_W(WD_SEL_W)) u_chk (
    .clk_i      (clk_int),
    .rst_i      (rst),
    .sel_main_i (sel_main),
    .fallback_i (fallback),
    .cpu_run_i  (cpu_run),
    .wr_lock_i  (wr_lock),
    .main_lost_i(main_lost),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .wd_run_i   (wd_run),
    .wd_over_i  (wd_over),
    .stab_done_i(stab_done),
    .wd_sel_i   (wd_sel)
);

// File: tb/osc_race_sup_tb_top.sv
`timescale 1ns/1ps
module osc_race_sup_tb_top;

    logic       clk_int = 1'b0;
    logic       clk_main = 1'b0;
    logic       main_on = 1'b1;
    logic       rst = 1'b1;
    logic       opt_long = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic       main_lost = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       sel_main, fallback, cpu_run, wr_lock, misconfig;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int run_cyc = 0;

    always #2.5 clk_int = ~clk_int;
    always #0.5 if (main_on) clk_main = ~clk_main;
    always @(posedge clk_int) cyc++;

    osc_race_sup dut_i (
        .clk_int  (clk_int),
        .clk_main (clk_main),
        .rst      (rst),
        .opt_long (opt_long),
        .stop_req (stop_req),
        .wake_irq (wake_irq),
        .main_lost(main_lost),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .sel_main (sel_main),
        .fallback (fallback),
        .cpu_run  (cpu_run),
        .wr_lock  (wr_lock),
        .misconfig(misconfig)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_int);
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_irq = 1'b1; tick(1); wake_irq = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
        tick(2);
    endtask

    // counts cycles until cpu_run; reports whether sel_main was stable the cycle before
    task automatic wait_run(output int n, output bit sel_ok);
        logic prev_sel;
        n = 0;
        prev_sel = sel_main;
        sel_ok = 1'b1;
        while (!cpu_run && n < 20000) begin
            prev_sel = sel_main;
            tick(1);
            n++;
        end
        sel_ok = (prev_sel == sel_main);
        run_cyc = cyc;
    endtask

    task automatic t_reset_race(input logic opt, input int lo, input int hi, input string tag);
        int  n;
        bit  ok;
        rst = 1'b1; opt_long = opt; main_on = 1'b1;
        tick(4);
        check(cpu_run == 1'b0, "R1 cpu_run in reset", cpu_run, 0);
        check(sel_main == 1'b0, "R1 sel_main in reset", sel_main, 0);
        check(fallback == 1'b0, "R6 reset clears fallback", fallback, 0);
        rst = 1'b0;
        tick(10);
        check(cpu_run == 1'b0, "R1 cpu held during race", cpu_run, 0);
        wait_run(n, ok);
        check(n >= lo && n <= hi, tag, n, lo);
        check(sel_main == 1'b1 && fallback == 1'b0, "R2 normal mode after main wins",
              {sel_main, fallback}, 2);
        check(ok, "R11 sel stable when cpu_run rises", 0, 1);
    endtask

    task automatic t_misconfig();
        wr(1'b0, 4'd8);
        check(misconfig == 1'b1, "R10 flag with stab 2^21 vs wd 2^19", misconfig, 1);
        wr(1'b0, 4'd0);
        check(misconfig == 1'b0, "R10 flag clear with stab 2^13", misconfig, 0);
    endtask

    task automatic t_stop_normal();
        int n;
        bit ok;
        wr(1'b1, 4'd0);
        pulse_stop();
        tick(1);
        check(cpu_run == 1'b0, "R7 stop halts cpu", cpu_run, 0);
        tick(20);
        pulse_wake();
        wait_run(n, ok);
        check(n >= 1630 && n <= 1680, "R7 wake race with stab 2^13 vs wd 2^12", n, 1645);
        check(sel_main == 1'b1 && fallback == 1'b0, "R7 normal after wake", {sel_main, fallback}, 2);
    endtask

    task automatic t_fallback();
        int n;
        bit ok;
        pulse_stop();
        tick(5);
        main_on = 1'b0;
        tick(5);
        pulse_wake();
        wait_run(n, ok);
        check(n >= 4090 && n <= 4110, "R5 wd 2^12 overflow time", n, 4097);
        check(fallback == 1'b1 && sel_main == 1'b0, "R3 fallback on dead main clock",
              {fallback, sel_main}, 2);
        check(wr_lock == 1'b1, "R8 lock active at cpu start", wr_lock, 1);
        check(ok, "R11 sel stable at fallback start", 0, 1);
    endtask

    task automatic t_lockout();
        wr(1'b0, 4'd4);
        check(misconfig == 1'b1, "R4 stab write allowed in lockout", misconfig, 1);
        wr(1'b1, 4'd7);
        check(misconfig == 1'b1, "R8 wd write ignored in lockout", misconfig, 1);
        while (cyc < run_cyc + 1000) tick(1);
        check(wr_lock == 1'b1, "R8 lock still held at 1000", wr_lock, 1);
        while (cyc < run_cyc + 1030) tick(1);
        check(wr_lock == 1'b0, "R8 lock released by 1030", wr_lock, 0);
        wr(1'b1, 4'd7);
        check(misconfig == 1'b0, "R8 wd write taken after lockout", misconfig, 0);
    endtask

    task automatic t_sticky();
        main_on = 1'b1;
        tick(10);
        pulse_stop();
        tick(2);
        check(cpu_run == 1'b1 && fallback == 1'b1, "R6 stop ignored in fallback",
              {cpu_run, fallback}, 3);
        pulse_wake();
        wr(1'b0, 4'd0);
        tick(2);
        check(fallback == 1'b1 && sel_main == 1'b0, "R6 fallback kept after wake and writes",
              {fallback, sel_main}, 2);
    endtask

    task automatic t_monitor();
        main_lost = 1'b1; tick(1); main_lost = 1'b0;
        tick(1);
        check(fallback == 1'b1 && sel_main == 1'b0, "R9 monitor forces fallback",
              {fallback, sel_main}, 2);
        check(cpu_run == 1'b1 && wr_lock == 1'b1, "R9 cpu keeps running, lock starts",
              {cpu_run, wr_lock}, 3);
    endtask

    initial begin
        tick(1);
        t_reset_race(1'b0, 1630, 1680, "R4 default stab 2^13 race time");
        t_misconfig();
        t_stop_normal();
        t_fallback();
        t_lockout();
        t_sticky();
        t_reset_race(1'b1, 6540, 6600, "R4 option stab 2^15 race time");
        t_monitor();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_int);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule